// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers interrupt requests from eight peripheral lines and presents a single interrupt to the processor. A rising edge on a request line records a pending bit. The unmasked pending bits are ranked by the current priority scheme. When the best of them outranks everything the processor is already servicing, the interrupt output rises. The processor then pulses an acknowledge. That moves the winning source from pending to in-service and returns a vector, one cycle later, that is a programmable base plus the source number.

Software chooses between two schemes with a control write. In fixed priority, line 0 is the most urgent and line 7 the least. In rotating priority, every line has equal standing: a source that has just been serviced drops to the bottom of the order, and its numeric successor moves to the top. A mask register hides selected lines from arbitration without discarding their requests. An end-of-service pulse retires the highest-priority in-service source.

Top module: `prio_intc`

## Requirements
- R1: After reset the interrupt output and the vector-valid output are low, no line is masked, fixed priority is selected and the vector base is 0.
- R2: A 0-to-1 transition of `irq_req_i[n]` sets pending bit n, and `irq_o` reflects it one clock later. A line held high does not set the bit again after it has been acknowledged.
- R3: In fixed priority (control bit `cfg_rotate_i` = 0), a lower line number always wins over a higher one.
- R4: Acknowledging while `irq_o` is high makes `vec_valid_o` high for exactly the next cycle, with `vec_o` = (base + winning line number) modulo 256.
- R5: An acknowledge clears the winner's pending bit and sets its in-service bit.
- R6: `irq_o` is high only when the best unmasked pending source has strictly higher priority than every in-service source.
- R7: An end-of-service pulse clears only the highest-priority in-service bit.
- R8: In rotating priority (`cfg_rotate_i` = 1), an end-of-service for line n makes line n the lowest priority, line n+1 (modulo 8) the highest, and the rest follow in ascending cyclic order.
- R9: A line whose bit in the mask register is 1 still records its request but is left out of arbitration until its mask bit returns to 0.
- R10: A control write loads the mode and the vector base and restores line 0 as the highest priority.
- R11: An acknowledge while `irq_o` is low produces no vector and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 8 | Request lines; a rising edge records a request |
| cfg_we_i | input | 1 | Control write strobe |
| cfg_rotate_i | input | 1 | Mode written on a control write: 0 fixed, 1 rotating |
| cfg_base_i | input | 8 | Vector base written on a control write |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_i | input | 8 | Mask value; 1 hides the line from arbitration |
| ack_i | input | 1 | Acknowledge pulse from the processor |
| eoi_i | input | 1 | End-of-service pulse from the processor |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_valid_o | output | 1 | Vector valid, one cycle after a granted acknowledge |
| vec_o | output | 8 | Vector of the granted source |

## Verification
The stimulus targets nesting, in two situations. In the first, a lower-priority request arrives while a higher source is in service. A design that compares against pending bits only, or uses a non-strict comparison, would raise the interrupt here. In the second, two end-of-service pulses retire sources one at a time, and retiring the wrong bit would release the waiting request too early. Rotating priority is tested across the wrap from line 7 back to line 0, where a pointer that failed to wrap, or that was not reset by a control write, would pick the wrong winner. The remaining cases are these: a masked request that must surface after unmasking, a request line held high that must not reassert, a vector sum that overflows eight bits, and an acknowledge with nothing eligible, which must stay silent.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  typedef enum logic {
    PRI_FIXED  = 1'b0,
    PRI_ROTATE = 1'b1
  } pri_mode_e;
endpackage

// File: rtl/prio_req_latch.sv
module prio_req_latch #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] irr_o
);
  logic [N-1:0] prev_q, irr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= req_i;
      irr_q  <= (irr_q & ~clr_i) | (req_i & ~prev_q);
    end
  end

  assign irr_o = irr_q;

  for (genvar g = 0; g < N; g++) begin : g_chk
    AST_EDGE_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(req_i[g]) |=> irr_o[g]); // R2
  end
endmodule

// File: rtl/prio_resolve.sv
module prio_resolve #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  input  logic [IW-1:0] low_i,
  output logic          any_o,
  output logic [IW-1:0] id_o,
  output logic [IW-1:0] rank_o
);
  logic [IW-1:0] top;
  logic [N-1:0]  rot;

  assign top = low_i + IW'(1);

  // rot[k] is the source at rank k (rank 0 = highest)
  for (genvar g = 0; g < N; g++) begin : g_rot
    localparam logic [IW-1:0] OFS = IW'(g);
    logic [IW-1:0] idx;
    assign idx    = top + OFS;
    assign rot[g] = vec_i[idx];
  end

  always_comb begin
    rank_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (rot[k]) rank_o = IW'(k);
    end
  end

  assign any_o = |rot;
  assign id_o  = top + rank_o;
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int VW    = 8,
  localparam int IW   = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_req_i,
  input  logic             cfg_we_i,
  input  logic             cfg_rotate_i,
  input  logic [VW-1:0]    cfg_base_i,
  input  logic             mask_we_i,
  input  logic [N_SRC-1:0] mask_i,
  input  logic             ack_i,
  input  logic             eoi_i,
  output logic             irq_o,
  output logic             vec_valid_o,
  output logic [VW-1:0]    vec_o
);
  localparam logic [IW-1:0] LOW_RST = IW'(N_SRC - 1);

  pri_mode_e        mode_q;
  logic [VW-1:0]    base_q, vec_q;
  logic [IW-1:0]    low_q, eff_low;
  logic [N_SRC-1:0] mask_q, isr_q, irr, ack_set, eoi_clr;
  logic             vec_valid_q, grant;
  logic             req_any, isr_any;
  logic [IW-1:0]    req_id, req_rank, isr_id, isr_rank;

  prio_req_latch #(.N(N_SRC)) u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (irq_req_i),
    .clr_i (ack_set),
    .irr_o (irr)
  );

  assign eff_low = (mode_q == PRI_ROTATE) ? low_q : LOW_RST;

  prio_resolve #(.N(N_SRC), .IW(IW)) u_req_res (
    .vec_i (irr & ~mask_q),
    .low_i (eff_low),
    .any_o (req_any),
    .id_o  (req_id),
    .rank_o(req_rank)
  );

  prio_resolve #(.N(N_SRC), .IW(IW)) u_isr_res (
    .vec_i (isr_q),
    .low_i (eff_low),
    .any_o (isr_any),
    .id_o  (isr_id),
    .rank_o(isr_rank)
  );

  // strict nesting: only a better-ranked request interrupts
  assign irq_o = req_any && (!isr_any || (req_rank < isr_rank));
  assign grant = ack_i && irq_o;

  always_comb begin
    for (int i = 0; i < N_SRC; i++) begin
      ack_set[i] = grant && (req_id == IW'(i));
      eoi_clr[i] = eoi_i && isr_any && (isr_id == IW'(i));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= PRI_FIXED;
      base_q      <= '0;
      low_q       <= LOW_RST;
      mask_q      <= '0;
      isr_q       <= '0;
      vec_q       <= '0;
      vec_valid_q <= 1'b0;
    end else begin
      isr_q       <= (isr_q & ~eoi_clr) | ack_set;
      vec_valid_q <= grant;
      if (grant) vec_q <= base_q + VW'(req_id);
      if (mask_we_i) mask_q <= mask_i;
      if (cfg_we_i) begin
        mode_q <= pri_mode_e'(cfg_rotate_i);
        base_q <= cfg_base_i;
        low_q  <= LOW_RST;
      end else if (eoi_i && isr_any && mode_q == PRI_ROTATE) begin
        low_q <= isr_id;
      end
    end
  end

  assign vec_valid_o = vec_valid_q;
  assign vec_o       = vec_q;

  AST_VALID_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> $past(ack_i && irq_o)); // R4
  AST_IDLE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o) |=> !vec_valid_o); // R11
  AST_ISR_GROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && !eoi_i) |=> $countones(isr_q) == $past($countones(isr_q)) + 1); // R5
  AST_EOI_SHRINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !ack_i && (|isr_q)) |=> $countones(isr_q) == $past($countones(isr_q)) - 1); // R7
  AST_IRQ_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |(irr & ~mask_q)); // R9
endmodule

// File: tb/tb_prio_intc.sv
`timescale 1ns/1ps
module tb_prio_intc;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] irq_req_i = '0;
  logic       cfg_we_i = 1'b0, cfg_rotate_i = 1'b0;
  logic [7:0] cfg_base_i = '0;
  logic       mask_we_i = 1'b0;
  logic [7:0] mask_i = '0;
  logic       ack_i = 1'b0, eoi_i = 1'b0;
  logic       irq_o, vec_valid_o;
  logic [7:0] vec_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0] got_vec;
  logic       got_valid;

  always #2.5 clk_i = ~clk_i;

  prio_intc dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_req_i(irq_req_i),
    .cfg_we_i(cfg_we_i), .cfg_rotate_i(cfg_rotate_i), .cfg_base_i(cfg_base_i),
    .mask_we_i(mask_we_i), .mask_i(mask_i), .ack_i(ack_i), .eoi_i(eoi_i),
    .irq_o(irq_o), .vec_valid_o(vec_valid_o), .vec_o(vec_o)
  );

  // {request pattern, expected winner} in fixed mode
  localparam int NV = 6;
  localparam logic [10:0] VEC_TBL [NV] = '{
    {8'h01, 3'd0}, {8'h80, 3'd7}, {8'hF0, 3'd4},
    {8'h0A, 3'd1}, {8'h60, 3'd5}, {8'hFF, 3'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
  endtask

  task automatic do_ack();
    ack_i = 1'b1; cyc(); ack_i = 1'b0;
    got_vec = vec_o; got_valid = vec_valid_o;
  endtask

  task automatic do_eoi();
    eoi_i = 1'b1; cyc(); eoi_i = 1'b0;
  endtask

  task automatic cfg(input logic rot, input logic [7:0] base);
    cfg_we_i = 1'b1; cfg_rotate_i = rot; cfg_base_i = base; cyc(); cfg_we_i = 1'b0;
  endtask

  task automatic set_mask(input logic [7:0] m);
    mask_we_i = 1'b1; mask_i = m; cyc(); mask_we_i = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 16; i++) begin
      if (irq_o) begin do_ack(); do_eoi(); end
      else cyc();
    end
  endtask

  task automatic ack_expect(input string req, input logic [7:0] exp);
    do_ack();
    check(req, {31'd0, got_valid}, 32'd1);
    check(req, {24'd0, got_vec}, {24'd0, exp});
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    check("R1 irq in reset", {31'd0, irq_o}, 32'd0);
    check("R1 valid in reset", {31'd0, vec_valid_o}, 32'd0);
    rst_ni = 1'b1; cyc();
    check("R1 irq after reset", {31'd0, irq_o}, 32'd0);
    // R1 defaults: fixed, base 0, unmasked
    irq_req_i = 8'h44; cyc();
    ack_expect("R1 default vector", 8'h02);
    do_eoi(); irq_req_i = '0; drain();

    cfg(1'b0, 8'h20);
    for (int t = 0; t < NV; t++) begin
      irq_req_i = VEC_TBL[t][10:3]; cyc();
      check("R2 irq after edge", {31'd0, irq_o}, 32'd1);
      ack_expect("R3 fixed winner", 8'h20 + {5'd0, VEC_TBL[t][2:0]});
      do_eoi();
      check("R4 valid one cycle", {31'd0, vec_valid_o}, 32'd0);
      irq_req_i = '0; drain();
    end

    // R6 nesting, R7 end-of-service order
    irq_req_i = 8'h08; cyc();
    ack_expect("R5 ack IR3", 8'h23);
    irq_req_i = 8'h28; cyc();
    check("R6 lower blocked", {31'd0, irq_o}, 32'd0);
    irq_req_i = 8'h2A; cyc();
    check("R6 higher nests", {31'd0, irq_o}, 32'd1);
    ack_expect("R6 nested vector", 8'h21);
    do_eoi();
    check("R7 IR3 still in service", {31'd0, irq_o}, 32'd0);
    do_eoi();
    check("R7 IR3 retired", {31'd0, irq_o}, 32'd1);
    ack_expect("R7 IR5 served", 8'h25);
    do_eoi(); irq_req_i = '0; cyc();
    check("R5 pending cleared", {31'd0, irq_o}, 32'd0);

    // R11 idle acknowledge
    do_ack();
    check("R11 no vector", {31'd0, got_valid}, 32'd0);
    irq_req_i = 8'h10; cyc();
    ack_expect("R11 state intact", 8'h24);
    do_eoi(); cyc();
    check("R2 held line no relatch", {31'd0, irq_o}, 32'd0);
    irq_req_i = '0; cyc(); irq_req_i = 8'h10; cyc();
    check("R2 new edge latches", {31'd0, irq_o}, 32'd1);
    do_ack(); do_eoi(); irq_req_i = '0; cyc();

    // R9 masking
    set_mask(8'h01);
    irq_req_i = 8'h01; cyc();
    check("R9 masked silent", {31'd0, irq_o}, 32'd0);
    irq_req_i = 8'h05; cyc();
    ack_expect("R9 masked skipped", 8'h22);
    do_eoi();
    check("R9 still masked", {31'd0, irq_o}, 32'd0);
    set_mask(8'h00);
    check("R9 latched surfaces", {31'd0, irq_o}, 32'd1);
    ack_expect("R9 unmasked vector", 8'h20);
    do_eoi(); irq_req_i = '0; drain();

    // R4 vector wrap
    cfg(1'b0, 8'hFE);
    irq_req_i = 8'h08; cyc();
    ack_expect("R4 base wrap", 8'h01);
    do_eoi(); irq_req_i = '0; drain();

    // R8 rotating priority
    cfg(1'b1, 8'h40);
    irq_req_i = 8'h44; cyc();
    ack_expect("R10 IR0 first after cfg", 8'h42);
    do_eoi(); irq_req_i = '0; cyc();
    irq_req_i = 8'h0A; cyc();
    ack_expect("R8 IR3 after IR2", 8'h43);
    do_eoi();
    ack_expect("R8 IR6 next", 8'h46);
    do_eoi();
    ack_expect("R8 IR1 last", 8'h41);
    do_eoi(); irq_req_i = '0; cyc();
    irq_req_i = 8'h05; cyc();
    ack_expect("R8 wrap IR2 over IR0", 8'h42);
    do_eoi(); irq_req_i = '0; cyc();

    // R10 control write restores order (IR0 still pending)
    cfg(1'b1, 8'h40);
    irq_req_i = 8'h20; cyc();
    ack_expect("R10 IR0 over IR5", 8'h40);
    do_eoi();
    ack_expect("R10 IR5 follows", 8'h45);
    do_eoi(); irq_req_i = '0; cyc();
    check("R5 all served", {31'd0, irq_o}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule